// File: doc/BRIEF.md
# Dual-Mode Parallel Host Bus Slave

This block lets an external 8-bit asynchronous microprocessor bus reach an on-chip mailbox register port. The host supplies a 9-bit address, an 8-bit data bus and an active-low chip select, plus two control pins. A 2-bit strap input sets what those two pins mean. In one style the pins are a read/write level and a data strobe. In the other style they are separate read and write strobes. Both styles share a single active-low ready/acknowledge handshake.

The chip select and both control pins pass through two-flop synchronizers. A falling strobe seen while chip select is low starts exactly one mailbox access. For a write, the address and data are captured when the cycle starts, and the mailbox write pulse follows. For a read, the block fetches the mailbox byte and drives it on the data bus, then acknowledges.

The pad drivers are outside this block. Every three-state pin is therefore split into a value and an enable. The open-drain interrupt pin is reduced to a single "pull low" control that follows the mailbox interrupt.

Top module: `hostbus_mbx_slave`

## Requirements
- R1: With `hb_mode` = 2'b00, `hb_ctl_a` is a read/write level (1 = read, 0 = write) and `hb_ctl_b` is an active-low data strobe.
- R2: With `hb_mode` = 2'b01, `hb_ctl_a` is an active-low write strobe and `hb_ctl_b` is an active-low read strobe.
- R3: With `hb_mode[1]` = 1, strobes cause no mailbox access. In that mode neither ready nor data is enabled, and mailbox contents stay unchanged.
- R4: A cycle starts only when the synchronized strobe falls while the synchronized chip select is low. A strobe with chip select high does nothing.
- R5: A write produces exactly one single-clock `mb_wr` pulse carrying the captured address and data. Counting the first rising edge after the strobe falls as edge 1, the pulse is high between edges 4 and 5.
- R6: A read drives the mailbox byte on `hb_dq_o` with `hb_dq_oe` high after edge 4. Ready goes low after edge 5, one clock after the data became valid.
- R7: `hb_rdy_oe` is high only while a cycle is active. `hb_rdy_n_o` goes low after edge 5 for both reads and writes. After the strobe returns high, the ready output returns to high impedance after the third rising edge.
- R8: Read data stops being driven when the strobe returns high or when chip select returns high, on the same timing as R7.
- R9: `hb_irq_pull` (1 = pull the open-drain interrupt pin low, 0 = high impedance) equals `mb_irq` delayed by one clock.
- R10: During and right after reset, no output enable, no mailbox strobe and no interrupt pull is active.
- R11: Holding a strobe low for a long time performs only one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_mode | input | 2 | Control-style strap |
| hb_cs_n | input | 1 | Host chip select, active low |
| hb_ctl_a | input | 1 | Control pin A (read/write level or write strobe) |
| hb_ctl_b | input | 1 | Control pin B (data strobe or read strobe) |
| hb_addr | input | 9 | Host address |
| hb_dq_i | input | 8 | Host data bus, input side |
| hb_dq_o | output | 8 | Host data bus, output value |
| hb_dq_oe | output | 1 | Host data bus drive enable |
| hb_rdy_n_o | output | 1 | Ready/acknowledge value, active low |
| hb_rdy_oe | output | 1 | Ready/acknowledge drive enable |
| hb_irq_pull | output | 1 | Pull interrupt pin low when 1 |
| mb_addr | output | 9 | Mailbox address |
| mb_wdata | output | 8 | Mailbox write data |
| mb_wr | output | 1 | Mailbox write pulse |
| mb_rd | output | 1 | Mailbox read request |
| mb_rdata | input | 8 | Mailbox read data for `mb_addr` |
| mb_irq | input | 1 | Mailbox interrupt request |

## Verification
Suppose the cycle sequencer ends up in a wrong state. The host then sees a ready that never falls, falls too early, or never returns to high impedance. The bench measures these by counting edges from each strobe change, so a one-state slip shows as a latency off by one clock. A decode fault, such as a swapped strobe role or a reserved mode that is accepted, shows as a missing or extra mailbox write. The bench catches this on the read-back that follows within a few dozen clocks. A stuck data enable shows as read data still driven after the host has released the bus.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WHOLD  = 3'd1,
    ST_WPUSH  = 3'd2,
    ST_RFETCH = 3'd3,
    ST_RSHOW  = 3'd4,
    ST_ACK    = 3'd5
  } cyc_state_t;

  typedef struct packed {
    logic valid;   // control style is a defined one
    logic strb_n;  // combined active-low strobe
    logic rnw;     // 1 = read cycle
  } ctl_view_t;

  // Interpret the two control pins according to the strap.
  function automatic ctl_view_t decode_ctl(input logic [1:0] mode,
                                           input logic pin_a,
                                           input logic pin_b);
    ctl_view_t v;
    v = '{valid: 1'b0, strb_n: 1'b1, rnw: 1'b1};
    case (mode)
      2'b00: begin
        v.valid  = 1'b1;
        v.strb_n = pin_b;
        v.rnw    = pin_a;
      end
      2'b01: begin
        v.valid  = 1'b1;
        v.strb_n = pin_a & pin_b;
        v.rnw    = ~pin_b;
      end
      default: v = '{valid: 1'b0, strb_n: 1'b1, rnw: 1'b1};
    endcase
    return v;
  endfunction

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RESET_VAL;
        else if (s == 0) chain[s] <= d_i;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hbs_strobe_decode.sv
module hbs_strobe_decode
  import hbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       cs_n_s,
  input  logic       pin_a_s,
  input  logic       pin_b_s,
  output logic       start_o,
  output logic       rnw_o,
  output logic       rel_o
);
  ctl_view_t view;
  logic      strb_prev;

  always_comb view = decode_ctl(mode, pin_a_s, pin_b_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_prev <= 1'b1;
    else        strb_prev <= view.strb_n;
  end

  assign start_o = view.valid & strb_prev & ~view.strb_n & ~cs_n_s;
  assign rnw_o   = view.rnw;
  assign rel_o   = view.strb_n | cs_n_s;
endmodule

// File: rtl/hbs_cycle_fsm.sv
module hbs_cycle_fsm
  import hbs_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rnw_i,
  input  logic              rel_i,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data,
  input  logic [DATA_W-1:0] mb_rdata,
  output logic [ADDR_W-1:0] mb_addr,
  output logic [DATA_W-1:0] mb_wdata,
  output logic              mb_wr,
  output logic              mb_rd,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              rdy_n_o,
  output logic              rdy_oe,
  output cyc_state_t        state_o
);
  cyc_state_t        st, st_nx;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q, rdat_q;
  logic              oe_q;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:   if (start_i) st_nx = rnw_i ? ST_RFETCH : ST_WHOLD;
      ST_WHOLD:  st_nx = ST_WPUSH;
      ST_WPUSH:  st_nx = ST_ACK;
      ST_RFETCH: st_nx = ST_RSHOW;
      ST_RSHOW:  st_nx = ST_ACK;
      ST_ACK:    if (rel_i) st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == ST_IDLE && start_i) begin
        addr_q <= host_addr;
        wdat_q <= host_data;
      end
      if (st == ST_RFETCH) begin
        rdat_q <= mb_rdata;
        oe_q   <= 1'b1;
      end else if (st_nx == ST_IDLE) begin
        oe_q   <= 1'b0;
      end
    end
  end

  assign mb_addr  = addr_q;
  assign mb_wdata = wdat_q;
  assign mb_wr    = (st == ST_WPUSH);
  assign mb_rd    = (st == ST_RFETCH);
  assign dq_o     = rdat_q;
  assign dq_oe    = oe_q;
  assign rdy_oe   = (st != ST_IDLE);
  assign rdy_n_o  = (st != ST_ACK);
  assign state_o  = st;
endmodule

// File: rtl/hostbus_mbx_slave.sv
module hostbus_mbx_slave
  import hbs_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        hb_mode,
  input  logic              hb_cs_n,
  input  logic              hb_ctl_a,
  input  logic              hb_ctl_b,
  input  logic [ADDR_W-1:0] hb_addr,
  input  logic [DATA_W-1:0] hb_dq_i,
  output logic [DATA_W-1:0] hb_dq_o,
  output logic              hb_dq_oe,
  output logic              hb_rdy_n_o,
  output logic              hb_rdy_oe,
  output logic              hb_irq_pull,
  output logic [ADDR_W-1:0] mb_addr,
  output logic [DATA_W-1:0] mb_wdata,
  output logic              mb_wr,
  output logic              mb_rd,
  input  logic [DATA_W-1:0] mb_rdata,
  input  logic              mb_irq
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] pins_s;
  logic             cs_sync, a_sync, b_sync;
  logic             cyc_start, cyc_rnw, cyc_rel;
  cyc_state_t       cyc_state;
  logic             irq_q;

  hbs_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({hb_cs_n, hb_ctl_a, hb_ctl_b}),
    .q_o   (pins_s)
  );
  assign {cs_sync, a_sync, b_sync} = pins_s;

  hbs_strobe_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (hb_mode),
    .cs_n_s  (cs_sync),
    .pin_a_s (a_sync),
    .pin_b_s (b_sync),
    .start_o (cyc_start),
    .rnw_o   (cyc_rnw),
    .rel_o   (cyc_rel)
  );

  hbs_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (cyc_start),
    .rnw_i     (cyc_rnw),
    .rel_i     (cyc_rel),
    .host_addr (hb_addr),
    .host_data (hb_dq_i),
    .mb_rdata  (mb_rdata),
    .mb_addr   (mb_addr),
    .mb_wdata  (mb_wdata),
    .mb_wr     (mb_wr),
    .mb_rd     (mb_rd),
    .dq_o      (hb_dq_o),
    .dq_oe     (hb_dq_oe),
    .rdy_n_o   (hb_rdy_n_o),
    .rdy_oe    (hb_rdy_oe),
    .state_o   (cyc_state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= mb_irq;
  end
  assign hb_irq_pull = irq_q;
endmodule

// File: rtl/hostbus_mbx_slave_chk.sv
module hostbus_mbx_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] hb_mode,
  input logic       cs_sync,
  input logic       cyc_start,
  input logic       mb_wr,
  input logic       mb_irq,
  input logic       hb_dq_oe,
  input logic       hb_rdy_n_o,
  input logic       hb_rdy_oe,
  input logic       hb_irq_pull
);
  a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    mb_wr |=> !mb_wr);

  a_r6_ack_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hb_rdy_n_o) |-> ($past(mb_wr) || $past(hb_dq_oe)));

  a_r8_data_inside_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    hb_dq_oe |-> hb_rdy_oe);

  a_r3_reserved_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    hb_mode[1] |-> !cyc_start);

  a_r4_start_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> !cs_sync);

  a_r9_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
    hb_irq_pull == $past(mb_irq));

  always @(negedge clk) begin
    if (!rst_n) begin
      a_r10_reset_quiet: assert (!hb_dq_oe && !hb_rdy_oe && !mb_wr && !hb_irq_pull);
    end
  end
endmodule

bind hostbus_mbx_slave hostbus_mbx_slave_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hb_mode     (hb_mode),
  .cs_sync     (cs_sync),
  .cyc_start   (cyc_start),
  .mb_wr       (mb_wr),
  .mb_irq      (mb_irq),
  .hb_dq_oe    (hb_dq_oe),
  .hb_rdy_n_o  (hb_rdy_n_o),
  .hb_rdy_oe   (hb_rdy_oe),
  .hb_irq_pull (hb_irq_pull)
);

// File: tb/hostbus_mbx_slave_tb.sv
module hostbus_mbx_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // {mode[1:0], read, addr[8:0], data[7:0], expect_ack}
  localparam logic [20:0] VEC [NVEC] = '{
    {2'b00, 1'b0, 9'h005, 8'hA5, 1'b1},
    {2'b01, 1'b0, 9'h1FF, 8'h3C, 1'b1},
    {2'b00, 1'b1, 9'h005, 8'hA5, 1'b1},
    {2'b01, 1'b1, 9'h1FF, 8'h3C, 1'b1},
    {2'b10, 1'b0, 9'h005, 8'hFF, 1'b0},
    {2'b11, 1'b0, 9'h1FF, 8'h00, 1'b0},
    {2'b00, 1'b1, 9'h005, 8'hA5, 1'b1},
    {2'b01, 1'b1, 9'h1FF, 8'h3C, 1'b1},
    {2'b01, 1'b0, 9'h000, 8'h81, 1'b1},
    {2'b00, 1'b1, 9'h000, 8'h81, 1'b1},
    {2'b10, 1'b1, 9'h000, 8'h00, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] hb_mode = 2'b00;
  logic       hb_cs_n = 1'b1, hb_ctl_a = 1'b1, hb_ctl_b = 1'b1;
  logic [8:0] hb_addr = '0;
  logic [7:0] hb_dq_i = '0;
  logic [7:0] hb_dq_o, mb_wdata, mb_rdata;
  logic       hb_dq_oe, hb_rdy_n_o, hb_rdy_oe, hb_irq_pull;
  logic [8:0] mb_addr;
  logic       mb_wr, mb_rd;
  logic       mb_irq = 1'b0;

  logic [7:0] mem [512];
  int         wr_cnt = 0;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostbus_mbx_slave dut_i (
    .clk(clk), .rst_n(rst_n), .hb_mode(hb_mode), .hb_cs_n(hb_cs_n),
    .hb_ctl_a(hb_ctl_a), .hb_ctl_b(hb_ctl_b), .hb_addr(hb_addr),
    .hb_dq_i(hb_dq_i), .hb_dq_o(hb_dq_o), .hb_dq_oe(hb_dq_oe),
    .hb_rdy_n_o(hb_rdy_n_o), .hb_rdy_oe(hb_rdy_oe), .hb_irq_pull(hb_irq_pull),
    .mb_addr(mb_addr), .mb_wdata(mb_wdata), .mb_wr(mb_wr), .mb_rd(mb_rd),
    .mb_rdata(mb_rdata), .mb_irq(mb_irq)
  );

  // Mailbox model
  initial for (int i = 0; i < 512; i++) mem[i] = 8'h00;
  always @(posedge clk) if (mb_wr) begin
    mem[mb_addr] <= mb_wdata;
    wr_cnt <= wr_cnt + 1;
  end
  assign mb_rdata = mem[mb_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Drive one host cycle; returns edges to ack, edges to release, and data.
  task automatic host_cycle(input logic [1:0] mode, input bit rd,
                            input logic [8:0] addr, input logic [7:0] data,
                            input int hold,
                            output int ack_lat, output int rel_lat,
                            output logic [7:0] rdata, output bit saw_oe,
                            output bit oe_at4);
    ack_lat = 0; rel_lat = 0; rdata = '0; saw_oe = 0; oe_at4 = 0;
    @(negedge clk);
    hb_mode = mode; hb_addr = addr; hb_dq_i = data; hb_cs_n = 1'b0;
    hb_ctl_a = (mode == 2'b00) ? rd : 1'b1; hb_ctl_b = 1'b1;
    repeat (3) @(negedge clk);
    if (mode == 2'b00)       hb_ctl_b = 1'b0;
    else if (mode == 2'b01) begin
      if (rd) hb_ctl_b = 1'b0; else hb_ctl_a = 1'b0;
    end else begin
      hb_ctl_a = 1'b0; hb_ctl_b = 1'b0;
    end
    for (int n = 1; n <= 12 + hold; n++) begin
      @(posedge clk); @(negedge clk);
      if (hb_rdy_oe || hb_dq_oe) saw_oe = 1;
      if (n == 4 && hb_dq_oe) oe_at4 = 1;
      if (ack_lat == 0 && hb_rdy_oe && !hb_rdy_n_o) begin
        ack_lat = n; rdata = hb_dq_o;
      end
    end
    hb_ctl_a = (mode == 2'b00) ? rd : 1'b1; hb_ctl_b = 1'b1;
    for (int n = 1; n <= 8; n++) begin
      @(posedge clk); @(negedge clk);
      if (rel_lat == 0 && !hb_rdy_oe && !hb_dq_oe) rel_lat = n;
    end
    hb_cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    int al, rl, w0;
    logic [7:0] rdv;
    bit soe, oe4;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!hb_dq_oe && !hb_rdy_oe && !mb_wr && !mb_rd && !hb_irq_pull, "R10 reset outputs",
        {hb_dq_oe, hb_rdy_oe, mb_wr, mb_rd, hb_irq_pull}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!hb_rdy_oe && !hb_dq_oe, "R10 after reset", {hb_rdy_oe, hb_dq_oe}, 0);

    // Vector table: R1, R2, R3, R5, R6, R7
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] m; bit r; logic [8:0] a; logic [7:0] d; bit ea;
      {m, r, a, d, ea} = VEC[v];
      w0 = wr_cnt;
      host_cycle(m, r, a, d, 0, al, rl, rdv, soe, oe4);
      if (ea) begin
        chk(al == 5, "R7 ack latency (R1/R2)", al, 5);
        chk(rl == 3, "R7 release latency", rl, 3);
        if (r) begin
          chk(rdv == d, "R6 read data", rdv, d);
          chk(oe4, "R6 data before ack", oe4, 1);
          chk(wr_cnt == w0, "R6 no write on read", wr_cnt - w0, 0);
        end else begin
          chk(wr_cnt == w0 + 1, "R5 one write", wr_cnt - w0, 1);
          chk(mem[a] == d, "R5 written byte", mem[a], d);
        end
      end else begin
        chk(!soe, "R3 reserved mode no drive", soe, 0);
        chk(wr_cnt == w0, "R3 reserved mode no write", wr_cnt - w0, 0);
      end
    end

    // R4: strobe with chip select high
    w0 = wr_cnt;
    @(negedge clk); hb_mode = 2'b00; hb_cs_n = 1'b1; hb_ctl_a = 1'b0; hb_addr = 9'h005; hb_dq_i = 8'h11;
    repeat (3) @(negedge clk); hb_ctl_b = 1'b0;
    soe = 0;
    for (int n = 0; n < 10; n++) begin @(negedge clk); if (hb_rdy_oe) soe = 1; end
    hb_ctl_b = 1'b1; repeat (4) @(negedge clk);
    chk(!soe, "R4 cs high no ready", soe, 0);
    chk(wr_cnt == w0 && mem[5] == 8'hA5, "R4 cs high no write", mem[5], 8'hA5);

    // R11: long strobe, one access
    w0 = wr_cnt;
    host_cycle(2'b01, 1'b0, 9'h0AA, 8'h5E, 40, al, rl, rdv, soe, oe4);
    chk(wr_cnt == w0 + 1, "R11 single access on long strobe", wr_cnt - w0, 1);
    chk(al == 5, "R11 ack latency", al, 5);

    // R8: read released by chip select
    @(negedge clk); hb_mode = 2'b00; hb_addr = 9'h0AA; hb_cs_n = 1'b0; hb_ctl_a = 1'b1; hb_ctl_b = 1'b1;
    repeat (3) @(negedge clk); hb_ctl_b = 1'b0;
    repeat (6) @(negedge clk);
    chk(hb_dq_oe && hb_dq_o == 8'h5E, "R8 read driven", hb_dq_o, 8'h5E);
    hb_cs_n = 1'b1;
    rl = 0;
    for (int n = 1; n <= 6; n++) begin
      @(posedge clk); @(negedge clk);
      if (rl == 0 && !hb_dq_oe && !hb_rdy_oe) rl = n;
    end
    chk(rl == 3, "R8 release by chip select", rl, 3);
    hb_ctl_b = 1'b1; repeat (4) @(negedge clk);

    // R9: interrupt follows with one clock
    mb_irq = 1'b1;
    chk(!hb_irq_pull, "R9 not yet", hb_irq_pull, 0);
    @(posedge clk); @(negedge clk);
    chk(hb_irq_pull, "R9 pull low", hb_irq_pull, 1);
    mb_irq = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(!hb_irq_pull, "R9 release", hb_irq_pull, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule